// File: doc/BRIEF.md
# Memory-Backed Packet FIFO Controller

This block is a packet FIFO whose bulk storage lives in external memory behind an AXI master port. Packets arrive on a valid/ready stream that carries a last-beat marker. Each packet is first held in a local write-data FIFO while its beats are counted. Once the whole packet is present, it goes out as a single AXI write burst into the next fixed-size segment of a ring of segments. When the write response comes back, a read job is queued. The packet is then fetched with one AXI read burst, and the read data is passed straight to the downstream stream.

A built-in segment ring hands out segment addresses in round-robin order from a base address. It reclaims each segment once the packet stored there has left the block, or has been discarded. The ring geometry and the base address are parameters, so the block needs no configuration port. The base address must be 4096-byte aligned, and the segment size must be a power of two no larger than 4096. Together these mean that no burst crosses a 4 KB boundary.

The read side has no buffer: the R channel is handed directly to the output. Read bursts are issued as soon as jobs are ready, without regard to how much read data the downstream can take.

Top module: `mem_pkt_fifo`

## Requirements
- R1: `in_ready` is 1 after reset. It is 0 whenever either of two queues is full: the write-data FIFO (default 1024 beats) or the queue of completed-packet lengths (default 8 entries).
- R2: Every write burst has size code 3 (8-byte beats for the default 64-bit bus) and burst type INCR (2'b01). Its address is BASE_ADDR + k*SEG_BYTES, where k counts write bursts modulo NUM_SEGS starting at 0. Its `m_awlen` equals the packet's beat count minus one.
- R3: The W beats carry the packet's input beats in order, with `m_wstrb` all ones. `m_wlast` is 1 on the last beat of the packet only.
- R4: A write burst starts only after the last beat of its packet has been accepted on the input. Exactly one burst is issued per packet, in arrival order.
- R5: A read burst for a packet is issued only after that packet's write response has been accepted with OKAY (2'b00). The read burst uses the same address and length as the write burst, size code 3 and INCR, and read bursts follow write order.
- R6: The output carries the R channel directly: `out_valid`/`out_data` follow `m_rvalid`/`m_rdata`, `m_rready` follows `out_ready`, and `out_last` marks the final beat of each burst. Packet boundaries are therefore kept.
- R7: A packet whose write response is not OKAY is dropped. It is never read or output, and its segment is reclaimed in ring order.
- R8: At most NUM_SEGS segments are in use at once. With the output stalled, exactly NUM_SEGS write bursts are issued, and no more until a segment is reclaimed.
- R9: Once `m_awvalid`, `m_wvalid` or `m_arvalid` is raised, it stays high with stable payload until its handshake completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with valid |
| in_data | input | DATA_W | Input beat data |
| in_last | input | 1 | Final beat of input packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream can accept a beat |
| out_data | output | DATA_W | Output beat data |
| out_last | output | 1 | Final beat of output packet |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write burst address |
| m_awlen | output | 8 | Write burst beats minus one |
| m_awsize | output | 3 | Write beat size code |
| m_awburst | output | 2 | Write burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes |
| m_wlast | output | 1 | Last write beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |
| m_arvalid | output | 1 | Read address valid |
| m_arready | input | 1 | Read address ready |
| m_araddr | output | ADDR_W | Read burst address |
| m_arlen | output | 8 | Read burst beats minus one |
| m_arsize | output | 3 | Read beat size code |
| m_arburst | output | 2 | Read burst type |
| m_rvalid | input | 1 | Read data valid |
| m_rready | output | 1 | Read data ready |
| m_rdata | input | DATA_W | Read data |
| m_rlast | input | 1 | Last read beat of burst |

## Verification
The in-RTL assertions watch, on every cycle, the properties that need no history beyond a few cycles. These are: no push into a full queue and no pop from an empty one; payload stability of AW, W and AR while they wait for ready; one write phase at a time; no release of a segment the ring has not handed out; and no read beat arriving without an outstanding read burst. The end-to-end behaviours can only be shown by the bench scenarios running against its own memory model. These cover data integrity through memory, burst addresses cycling around the ring, read bursts gated by OKAY responses, silent dropping of packets with error responses, and the ring and length queue filling up while the output is held off.

// File: rtl/mpf_pkg.sv
// Shared types and constants for the memory-backed packet FIFO.
// Assumes a single clock domain and AXI4 burst encodings.
package mpf_pkg;
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_ADDR = 2'd1,
        WR_DATA = 2'd2,
        WR_RESP = 2'd3
    } wr_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;
    localparam logic [1:0] RESP_OKAY  = 2'b00;
    localparam int         LEN_W      = 8;
endpackage

// File: rtl/mpf_sync_fifo.sv
// Synchronous first-word-fall-through FIFO.
// Assumes DEPTH is a power of two >= 2; callers never push when full
// nor pop when empty (checked below).
module mpf_sync_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    output logic             full,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             empty
);
    localparam int PW = $clog2(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [PW:0]      wr_ptr, rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[PW] != rd_ptr[PW]) && (wr_ptr[PW-1:0] == rd_ptr[PW-1:0]);
    assign rdata = store[rd_ptr[PW-1:0]];

    // Write the storage array on an accepted push.
    always_ff @(posedge clk) begin
        if (push && !full) store[wr_ptr[PW-1:0]] <= wdata;
    end

    // Advance read and write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push && !full) wr_ptr <= wr_ptr + 1'b1;
            if (pop && !empty) rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mpf_seg_ring.sv
// Ring of fixed-size memory segments handed out in round-robin order.
// Assumes releases happen in allocation order and never exceed the
// number allocated; NUM_SEGS >= 2.
module mpf_seg_ring #(
    parameter int          ADDR_W    = 28,
    parameter int unsigned BASE_ADDR = 0,
    parameter int unsigned SEG_BYTES = 2048,
    parameter int          NUM_SEGS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              release_seg,
    output logic              avail,
    output logic [ADDR_W-1:0] seg_addr
);
    localparam int IW = $clog2(NUM_SEGS);
    localparam int CW = $clog2(NUM_SEGS + 1);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SEG_A  = ADDR_W'(SEG_BYTES);

    logic [IW-1:0] next_idx;
    logic [CW-1:0] in_use;

    assign avail    = (in_use != CW'(NUM_SEGS));
    assign seg_addr = BASE_A + ADDR_W'(next_idx) * SEG_A;

    // Step the allocation index and track segments in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_idx <= '0;
            in_use   <= '0;
        end else begin
            if (alloc) next_idx <= (next_idx == IW'(NUM_SEGS - 1)) ? '0 : next_idx + 1'b1;
            in_use <= in_use + CW'(alloc) - CW'(release_seg);
        end
    end

    assert_alloc_when_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> avail);
    assert_release_owned_R8: assert property (@(posedge clk) disable iff (!rst_n)
        release_seg |-> (in_use != '0));
endmodule

// File: rtl/mpf_write_engine.sv
// Turns one buffered packet into one AXI write burst, then pushes a
// read job (address, length, drop flag) when the response arrives.
// Assumes the whole packet is in the data FIFO before its length
// entry appears; one write burst outstanding at a time.
module mpf_write_engine
    import mpf_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lq_empty,
    input  logic [LEN_W-1:0]  lq_len_m1,
    output logic              lq_pop,
    input  logic              df_empty,
    input  logic [DATA_W-1:0] df_data,
    output logic              df_pop,
    input  logic              seg_avail,
    input  logic [ADDR_W-1:0] seg_addr,
    output logic              seg_alloc,
    output logic              awvalid,
    input  logic              awready,
    output logic [ADDR_W-1:0] awaddr,
    output logic [LEN_W-1:0]  awlen,
    output logic              wvalid,
    input  logic              wready,
    output logic [DATA_W-1:0] wdata,
    output logic              wlast,
    input  logic              bvalid,
    output logic              bready,
    input  logic [1:0]        bresp,
    input  logic              job_full,
    output logic              job_push,
    output logic              job_drop,
    output logic [ADDR_W-1:0] job_addr,
    output logic [LEN_W-1:0]  job_len_m1
);
    wr_state_e         state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q, beat_q;
    logic              start;

    // Decode handshakes for the current phase.
    always_comb begin
        start      = (state_q == WR_IDLE) && !lq_empty && seg_avail;
        lq_pop     = start;
        seg_alloc  = start;
        awvalid    = (state_q == WR_ADDR);
        awaddr     = addr_q;
        awlen      = len_q;
        wvalid     = (state_q == WR_DATA) && !df_empty;
        wdata      = df_data;
        wlast      = (beat_q == len_q);
        df_pop     = wvalid && wready;
        bready     = (state_q == WR_RESP) && !job_full;
        job_push   = bvalid && bready;
        job_drop   = (bresp != RESP_OKAY);
        job_addr   = addr_q;
        job_len_m1 = len_q;
    end

    // Sequence address, data and response phases of one burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
            addr_q  <= '0;
            len_q   <= '0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                WR_IDLE: if (start) begin
                    addr_q  <= seg_addr;
                    len_q   <= lq_len_m1;
                    beat_q  <= '0;
                    state_q <= WR_ADDR;
                end
                WR_ADDR: if (awready) state_q <= WR_DATA;
                WR_DATA: if (df_pop) begin
                    beat_q <= beat_q + 1'b1;
                    if (wlast) state_q <= WR_RESP;
                end
                default: if (job_push) state_q <= WR_IDLE;
            endcase
        end
    end

    assert_aw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen));
    assert_w_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wlast));
    assert_one_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(awvalid && wvalid));
    assert_job_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && wlast |=> !wvalid);
endmodule

// File: rtl/mpf_read_engine.sv
// Pops read jobs, issues one AXI read burst per kept packet and passes
// the R channel straight to the output. Drop jobs release their segment
// only when no read burst is outstanding, so releases stay in ring order.
// Assumes R beats arrive in AR order (single ID).
module mpf_read_engine
    import mpf_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int ADDR_W   = 28,
    parameter int NUM_SEGS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              job_empty,
    input  logic              job_drop,
    input  logic [ADDR_W-1:0] job_addr,
    input  logic [LEN_W-1:0]  job_len_m1,
    output logic              job_pop,
    output logic              seg_release,
    output logic              arvalid,
    input  logic              arready,
    output logic [ADDR_W-1:0] araddr,
    output logic [LEN_W-1:0]  arlen,
    input  logic              rvalid,
    output logic              rready,
    input  logic [DATA_W-1:0] rdata,
    input  logic              rlast,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last
);
    localparam int CW = $clog2(NUM_SEGS + 1);

    logic              arv_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [CW-1:0]     pending;
    logic              take, ar_fire, r_done;

    // Job acceptance and R-to-output pass-through.
    always_comb begin
        take        = !arv_q && !job_empty && (!job_drop || pending == '0);
        job_pop     = take;
        ar_fire     = arv_q && arready;
        r_done      = rvalid && out_ready && rlast;
        seg_release = (take && job_drop) || r_done;
        arvalid     = arv_q;
        araddr      = addr_q;
        arlen       = len_q;
        out_valid   = rvalid;
        out_data    = rdata;
        out_last    = rlast;
        rready      = out_ready;
    end

    // Hold the read request and count bursts still returning data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arv_q   <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            pending <= '0;
        end else begin
            if (take && !job_drop) begin
                arv_q  <= 1'b1;
                addr_q <= job_addr;
                len_q  <= job_len_m1;
            end else if (ar_fire) begin
                arv_q <= 1'b0;
            end
            pending <= pending + CW'(ar_fire) - CW'(r_done);
        end
    end

    assert_ar_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && !arready |=> arvalid && $stable(araddr) && $stable(arlen));
    assert_r_expected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> (pending != '0));
    assert_pending_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= CW'(NUM_SEGS));
endmodule

// File: rtl/mem_pkt_fifo.sv
// Packet FIFO backed by external memory over AXI. Packets are counted
// into a local data FIFO, written as one burst per packet into a ring
// segment, then read back after an OKAY response.
// Assumes: packets of at most MAX_PKT_BYTES; BASE_ADDR 4096-aligned;
// SEG_BYTES a power of two <= 4096 that holds a full packet.
module mem_pkt_fifo
    import mpf_pkg::*;
#(
    parameter int          DATA_W          = 64,
    parameter int          ADDR_W          = 28,
    parameter int          MAX_PKT_BYTES   = 1526,
    parameter int          MAX_BURST_BEATS = 256,
    parameter int          DATA_FIFO_DEPTH = 1024,
    parameter int          LEN_FIFO_DEPTH  = 8,
    parameter int          JOB_FIFO_DEPTH  = 8,
    parameter int unsigned SEG_BYTES       = 2048,
    parameter int          NUM_SEGS        = 16,
    parameter int unsigned BASE_ADDR       = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [DATA_W-1:0]   in_data,
    input  logic                in_last,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_last,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [7:0]          m_awlen,
    output logic [2:0]          m_awsize,
    output logic [1:0]          m_awburst,
    output logic                m_wvalid,
    input  logic                m_wready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wlast,
    input  logic                m_bvalid,
    output logic                m_bready,
    input  logic [1:0]          m_bresp,
    output logic                m_arvalid,
    input  logic                m_arready,
    output logic [ADDR_W-1:0]   m_araddr,
    output logic [7:0]          m_arlen,
    output logic [2:0]          m_arsize,
    output logic [1:0]          m_arburst,
    input  logic                m_rvalid,
    output logic                m_rready,
    input  logic [DATA_W-1:0]   m_rdata,
    input  logic                m_rlast
);
    localparam int BEAT_BYTES    = DATA_W / 8;
    localparam int MAX_PKT_BEATS = (MAX_PKT_BYTES + BEAT_BYTES - 1) / BEAT_BYTES;
    localparam int JOB_W         = 1 + ADDR_W + LEN_W;

    if (MAX_PKT_BEATS > MAX_BURST_BEATS || MAX_PKT_BEATS * BEAT_BYTES > int'(SEG_BYTES)
        || (BASE_ADDR % 4096) != 0 || SEG_BYTES > 4096) begin : g_bad_cfg
        $error("mem_pkt_fifo: inconsistent geometry parameters");
    end

    logic             df_full, df_empty, df_pop;
    logic [DATA_W-1:0] df_data;
    logic             lq_full, lq_empty, lq_pop, lq_push;
    logic [LEN_W-1:0] lq_len_m1, beat_cnt;
    logic             seg_avail, seg_alloc, seg_release;
    logic [ADDR_W-1:0] seg_addr;
    logic             job_full, job_empty, job_push, job_pop, job_drop_w;
    logic [ADDR_W-1:0] job_addr_w;
    logic [LEN_W-1:0] job_len_w;
    logic [JOB_W-1:0] job_in, job_out;
    logic             in_fire;

    assign in_ready  = !df_full && !lq_full;
    assign in_fire   = in_valid && in_ready;
    assign lq_push   = in_fire && in_last;
    assign m_awsize  = 3'($clog2(BEAT_BYTES));
    assign m_arsize  = 3'($clog2(BEAT_BYTES));
    assign m_awburst = BURST_INCR;
    assign m_arburst = BURST_INCR;
    assign m_wstrb   = '1;
    assign job_in    = {job_drop_w, job_addr_w, job_len_w};

    // Count beats of the packet currently arriving.
    always_ff @(posedge clk) begin
        if (!rst_n)       beat_cnt <= '0;
        else if (lq_push) beat_cnt <= '0;
        else if (in_fire) beat_cnt <= beat_cnt + 1'b1;
    end

    assert_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_ready |=> in_valid && $stable(in_data) && $stable(in_last));
    assert_pkt_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> (beat_cnt < LEN_W'(MAX_PKT_BEATS)));

    mpf_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DATA_FIFO_DEPTH)) u_data_fifo (
        .clk(clk), .rst_n(rst_n), .push(in_fire), .wdata(in_data), .full(df_full),
        .pop(df_pop), .rdata(df_data), .empty(df_empty));

    mpf_sync_fifo #(.WIDTH(LEN_W), .DEPTH(LEN_FIFO_DEPTH)) u_len_fifo (
        .clk(clk), .rst_n(rst_n), .push(lq_push), .wdata(beat_cnt), .full(lq_full),
        .pop(lq_pop), .rdata(lq_len_m1), .empty(lq_empty));

    mpf_sync_fifo #(.WIDTH(JOB_W), .DEPTH(JOB_FIFO_DEPTH)) u_job_fifo (
        .clk(clk), .rst_n(rst_n), .push(job_push), .wdata(job_in), .full(job_full),
        .pop(job_pop), .rdata(job_out), .empty(job_empty));

    mpf_seg_ring #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .SEG_BYTES(SEG_BYTES),
                   .NUM_SEGS(NUM_SEGS)) u_ring (
        .clk(clk), .rst_n(rst_n), .alloc(seg_alloc), .release_seg(seg_release),
        .avail(seg_avail), .seg_addr(seg_addr));

    mpf_write_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .lq_empty(lq_empty), .lq_len_m1(lq_len_m1), .lq_pop(lq_pop),
        .df_empty(df_empty), .df_data(df_data), .df_pop(df_pop),
        .seg_avail(seg_avail), .seg_addr(seg_addr), .seg_alloc(seg_alloc),
        .awvalid(m_awvalid), .awready(m_awready), .awaddr(m_awaddr), .awlen(m_awlen),
        .wvalid(m_wvalid), .wready(m_wready), .wdata(m_wdata), .wlast(m_wlast),
        .bvalid(m_bvalid), .bready(m_bready), .bresp(m_bresp),
        .job_full(job_full), .job_push(job_push), .job_drop(job_drop_w),
        .job_addr(job_addr_w), .job_len_m1(job_len_w));

    mpf_read_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SEGS(NUM_SEGS)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .job_empty(job_empty), .job_drop(job_out[JOB_W-1]),
        .job_addr(job_out[JOB_W-2:LEN_W]), .job_len_m1(job_out[LEN_W-1:0]),
        .job_pop(job_pop), .seg_release(seg_release),
        .arvalid(m_arvalid), .arready(m_arready), .araddr(m_araddr), .arlen(m_arlen),
        .rvalid(m_rvalid), .rready(m_rready), .rdata(m_rdata), .rlast(m_rlast),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last));
endmodule

// File: tb/tb_mem_pkt_fifo.sv
module tb_mem_pkt_fifo;
    localparam int          DW    = 64;
    localparam int          AW    = 28;
    localparam int          NSEG  = 16;
    localparam int          LQD   = 8;
    localparam int unsigned SEGB  = 2048;
    localparam int unsigned BASE  = 32'h0010_0000;
    localparam int          MAXB  = 191;
    localparam int          MWORDS = NSEG * SEGB / 8;

    typedef struct packed { logic last; logic [DW-1:0] data; } beat_t;
    typedef struct packed { logic [AW-1:0] addr; logic [7:0] len; } burst_t;

    logic clk = 0, rst_n = 0;
    logic in_valid = 0, in_last = 0, out_ready = 0;
    logic [DW-1:0] in_data = '0;
    logic in_ready, out_valid, out_last;
    logic [DW-1:0] out_data;
    logic m_awvalid, m_awready = 0, m_wvalid, m_wready = 0, m_wlast;
    logic [AW-1:0] m_awaddr, m_araddr;
    logic [7:0] m_awlen, m_arlen, m_wstrb;
    logic [2:0] m_awsize, m_arsize;
    logic [1:0] m_awburst, m_arburst, m_bresp = 0;
    logic [DW-1:0] m_wdata, m_rdata = '0;
    logic m_bvalid = 0, m_bready, m_arvalid, m_arready = 0;
    logic m_rvalid = 0, m_rready, m_rlast = 0;

    always #2 clk = ~clk;

    mem_pkt_fifo #(.NUM_SEGS(NSEG), .SEG_BYTES(SEGB), .BASE_ADDR(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
        .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
        .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
        .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_bvalid(m_bvalid),
        .m_bready(m_bready), .m_bresp(m_bresp), .m_arvalid(m_arvalid),
        .m_arready(m_arready), .m_araddr(m_araddr), .m_arlen(m_arlen),
        .m_arsize(m_arsize), .m_arburst(m_arburst), .m_rvalid(m_rvalid),
        .m_rready(m_rready), .m_rdata(m_rdata), .m_rlast(m_rlast));

    int checks = 0, fails = 0;
    logic [DW-1:0] mem [MWORDS];
    beat_t  src_q[$], wexp_q[$], cur_pkt[$], exp_out[$];
    int     len_q[$];
    burst_t exp_ar[$], ar_q[$];
    int pkts_done = 0, aw_cnt = 0, out_pkts = 0, exp_pkts = 0, total_pkts = 0;
    int w_word = 0, w_beat = 0, r_beat = 0;
    bit cur_err = 0, b_pend = 0, inj_err = 0, stall = 0;
    bit f_in = 0, f_b = 0, f_r = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] seg_of(input int k);
        return AW'(BASE + (k % NSEG) * SEGB);
    endfunction

    task automatic add_pkt(input int beats);
        len_q.push_back(beats);
        total_pkts++;
        for (int i = 0; i < beats; i++) begin
            beat_t b;
            b.data = {$urandom, $urandom};
            b.last = (i == beats - 1);
            src_q.push_back(b);
            wexp_q.push_back(b);
        end
    endtask

    // Stimulus drivers and memory slave: drive at negedge, evaluate at negedge+1.
    initial begin
        forever begin
            @(negedge clk);
            if (f_in) begin void'(src_q.pop_front()); in_valid = 0; end
            if (!in_valid && src_q.size() > 0 && ($urandom % 4) != 0) begin
                in_valid = 1; {in_last, in_data} = src_q[0];
            end
            m_awready = $urandom % 2;
            m_wready  = ($urandom % 4) != 0;
            m_arready = $urandom % 2;
            if (f_b) m_bvalid = 0;
            if (!m_bvalid && b_pend && ($urandom % 2)) begin
                m_bvalid = 1; m_bresp = cur_err ? 2'b10 : 2'b00;
            end
            if (f_r) begin
                m_rvalid = 0;
                if (m_rlast) begin void'(ar_q.pop_front()); r_beat = 0; end
                else r_beat++;
            end
            if (!m_rvalid && ar_q.size() > 0 && ($urandom % 4) != 0) begin
                int wi;
                wi = int'((ar_q[0].addr - AW'(BASE)) >> 3) + r_beat;
                m_rvalid = 1; m_rdata = mem[wi]; m_rlast = (r_beat == int'(ar_q[0].len));
            end
            out_ready = stall ? 1'b0 : (($urandom % 4) != 0);
            #1;
            f_in = in_valid && in_ready;
            if (f_in && in_last) pkts_done++;
            if (m_awvalid && m_awready) begin
                int exp_len;
                exp_len = (len_q.size() > 0) ? len_q.pop_front() : 0;
                chk(pkts_done > aw_cnt, "R4 aw before packet complete", pkts_done, aw_cnt + 1);
                chk(m_awaddr == seg_of(aw_cnt), "R2 awaddr", m_awaddr, seg_of(aw_cnt));
                chk(int'(m_awlen) == exp_len - 1, "R2 awlen", m_awlen, exp_len - 1);
                chk(m_awsize == 3'd3 && m_awburst == 2'b01, "R2 size/burst",
                    {m_awsize, m_awburst}, 5'b01101);
                w_word = int'((m_awaddr - AW'(BASE)) >> 3);
                w_beat = 0;
                cur_err = inj_err && (aw_cnt % 5 == 2);
                aw_cnt++;
            end
            if (m_wvalid && m_wready) begin
                beat_t e;
                e = (wexp_q.size() > 0) ? wexp_q.pop_front() : '0;
                chk(m_wdata == e.data, "R3 wdata", m_wdata, e.data);
                chk(m_wlast == e.last, "R3 wlast", m_wlast, e.last);
                chk(m_wstrb == 8'hFF, "R3 wstrb", m_wstrb, 8'hFF);
                if (w_word + w_beat < MWORDS) mem[w_word + w_beat] = m_wdata;
                cur_pkt.push_back(e);
                w_beat++;
                if (m_wlast) b_pend = 1;
            end
            f_b = m_bvalid && m_bready;
            if (f_b) begin
                b_pend = 0;
                if (!cur_err) begin
                    burst_t bb;
                    bb.addr = AW'(BASE) + AW'(w_word * 8);
                    bb.len  = 8'(cur_pkt.size() - 1);
                    exp_ar.push_back(bb);
                    foreach (cur_pkt[i]) exp_out.push_back(cur_pkt[i]);
                    exp_pkts++;
                end
                cur_pkt.delete();
            end
            if (m_arvalid && m_arready) begin
                chk(exp_ar.size() > 0, "R5 ar without okay response", exp_ar.size(), 1);
                if (exp_ar.size() > 0) begin
                    burst_t x;
                    x = exp_ar.pop_front();
                    chk(m_araddr == x.addr, "R5/R7 araddr", m_araddr, x.addr);
                    chk(m_arlen == x.len, "R5 arlen", m_arlen, x.len);
                end
                chk(m_arsize == 3'd3 && m_arburst == 2'b01, "R5 ar size/burst",
                    {m_arsize, m_arburst}, 5'b01101);
                ar_q.push_back('{addr: m_araddr, len: m_arlen});
            end
            f_r = m_rvalid && m_rready;
            if (m_rvalid) begin
                chk(out_valid && out_data == m_rdata && out_last == m_rlast,
                    "R6 pass-through", {out_valid, out_last}, {1'b1, m_rlast});
            end
            chk(m_rready == out_ready, "R6 rready", m_rready, out_ready);
            if (out_valid && out_ready) begin
                beat_t e;
                e = (exp_out.size() > 0) ? exp_out.pop_front() : '0;
                chk(out_data == e.data, "R6 out_data", out_data, e.data);
                chk(out_last == e.last, "R6 out_last", out_last, e.last);
                if (out_last) out_pkts++;
            end
        end
    end

    task automatic drain(input int limit);
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (src_q.size() == 0 && exp_out.size() == 0 && aw_cnt == total_pkts
                && !b_pend && exp_ar.size() == 0 && ar_q.size() == 0) break;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", aw_cnt, total_pkts);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int base_aw;
        void'($urandom(32'h5EED_1234));
        repeat (4) @(posedge clk);
        @(negedge clk); #1;
        chk(in_ready == 1'b1, "R1 reset in_ready", in_ready, 1);
        chk(!m_awvalid && !m_wvalid && !m_arvalid && !m_bready, "R2 reset idle",
            {m_awvalid, m_wvalid, m_arvalid, m_bready}, 0);
        rst_n = 1;
        // Directed: shortest, longest, two-beat packets.
        add_pkt(1); add_pkt(MAXB); add_pkt(2);
        drain(20000);
        // Directed: output held off fills the ring and the length queue (R8, R1).
        stall = 1;
        base_aw = aw_cnt;
        for (int i = 0; i < NSEG + LQD + 2; i++) add_pkt(1);
        repeat (3000) @(negedge clk);
        #1;
        chk(aw_cnt - base_aw == NSEG - (aw_cnt - base_aw == NSEG ? 0 : 0) &&
            (aw_cnt - base_aw) <= NSEG, "R8 bursts while stalled", aw_cnt - base_aw, NSEG);
        chk((aw_cnt - base_aw) == NSEG - 3 + 3, "R8 ring exactly full", aw_cnt - base_aw, NSEG);
        chk(in_ready == 1'b0, "R1 length queue full", in_ready, 0);
        stall = 0;
        drain(40000);
        // Random traffic with error responses on some bursts (R7).
        inj_err = 1;
        for (int i = 0; i < 40; i++) add_pkt(1 + ($urandom % MAXB));
        drain(100000);
        inj_err = 0;
        add_pkt(3);
        drain(5000);
        repeat (20) @(negedge clk);
        chk(exp_out.size() == 0, "R7 all kept beats delivered", exp_out.size(), 0);
        chk(out_pkts == exp_pkts, "R7 kept packet count", out_pkts, exp_pkts);
        chk(out_pkts < total_pkts, "R7 dropped packets not output", out_pkts, total_pkts);
        chk(aw_cnt == total_pkts, "R4 one burst per packet", aw_cnt, total_pkts);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule